// File: doc/BRIEF.md
# Per-Channel Memory Error Cause Generator

This block sits beside a multi-channel memory controller. It turns the controller's raw per-channel event strobes and status levels into twelve level interrupt causes for each channel. The inputs are write and read data-parity errors, single- and double-bit ECC errors, on-die ECC reports, a catastrophic-temperature pin, a temperature-sensor value, training and initialisation completion flags, and a bundle of 21 further controller events. Every channel keeps a 32-bit sticky status word. Eleven of its bits drive an individual cause output. The other bits are folded into a single catch-all cause.

Single-bit ECC errors are also counted in a saturating counter. A further cause fires when that count goes past a programmable threshold. Each channel also gives one rollup line that summarises its correctable and uncorrectable error causes. Software uses a write-only configuration port to clear status bits (write-one-to-clear) and to set the per-channel threshold. The number of channels is a parameter.

Top module: `mem_err_cause_gen`

## Requirements
- R1: In each channel, a high event input sets its status bit at the next rising clock edge, and the bit stays set until it is cleared. Cause outputs `cause_o[12*c + k]` for k = 0..10 follow status bits 0..10 in this order: 0 write parity, 1 read parity, 2 single-bit ECC, 3 single-bit ECC over threshold, 4 double-bit ECC, 5 catastrophic temperature, 6 temperature change, 7 training done, 8 init done, 9 on-die single-bit ECC, 10 on-die double-bit ECC.
- R2: A write with `cfg_sel_i`=0 to channel `cfg_ch_i` clears each status bit whose `cfg_wdata_i` bit is 1. If a bit's event arrives in the same cycle as its clear, the set wins.
- R3: Cause 3 is set by a single-bit ECC event that brings the count strictly above the channel's threshold. An equal count does not set it, and a threshold change alone does not set it. A write with `cfg_sel_i`=1 loads the threshold from `cfg_wdata_i[CNT_W-1:0]`. The threshold resets to `THR_INIT` (default 4).
- R4: The single-bit ECC count saturates at 2^CNT_W−1. It returns to zero when status bit 2 is cleared; a single-bit ECC event in that same cycle counts as 1.
- R5: Cause 6 is set when the sampled temperature value differs from the value sampled one cycle earlier. No change is flagged in the first cycle after reset.
- R6: Causes 7 and 8 are set only on a low-to-high transition of the training-done and init-done flags. A flag that stays high does not set the cause again after a clear.
- R7: The catastrophic-temperature bit (bit 5) ignores write-one-to-clear. Only reset clears it.
- R8: Cause 11 is the OR of status bits 11..31, which are set by `extra_i[21*c + j]` into bit 11+j.
- R9: `rollup_o[c]` is the OR of causes 0, 1, 2, 3, 4, 9 and 10 of channel c.
- R10: Events and configuration writes for one channel leave every other channel's outputs unchanged.
- R11: While reset is asserted, and directly after it, every cause and rollup output is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_par_i | input | NCH | Write data-parity error strobe per channel |
| rd_par_i | input | NCH | Read data-parity error strobe per channel |
| sbe_i | input | NCH | Single-bit ECC error strobe per channel |
| dbe_i | input | NCH | Double-bit ECC error strobe per channel |
| od_sbe_i | input | NCH | On-die single-bit ECC strobe per channel |
| od_dbe_i | input | NCH | On-die double-bit ECC strobe per channel |
| cattrip_i | input | NCH | Catastrophic-temperature pin per channel |
| temp_i | input | NCH*TEMP_W | Temperature-sensor value, channel c at [TEMP_W*c +: TEMP_W] |
| train_done_i | input | NCH | Training-complete flag per channel |
| init_done_i | input | NCH | Init-complete flag per channel |
| extra_i | input | NCH*21 | Remaining controller events, channel c at [21*c +: 21] |
| cfg_we_i | input | 1 | Configuration write strobe |
| cfg_ch_i | input | CH_W | Channel addressed by the write |
| cfg_sel_i | input | 1 | 0: status clear, 1: threshold load |
| cfg_wdata_i | input | 32 | Write data |
| cause_o | output | NCH*12 | Cause levels, channel c at [12*c +: 12] |
| rollup_o | output | NCH | Error rollup per channel |

## Verification
A status bit that is stuck or lost shows on the matching cause output at the sample after the edge that should have set or cleared it, and on the rollup line in the same cycle. A counter that wraps instead of saturating, or that fails to reset, stays hidden until the next single-bit ECC strobe near the threshold. The bench therefore clears cause 3 and then sends one more strobe after running the counter past its limit. A wrong previous-value register in the edge or change detectors shows up as a spurious cause 6, 7 or 8, either one cycle after reset or after a clear while the flag stays high.

// File: rtl/mecg_pkg.sv
package mecg_pkg;
  localparam int NCAUSE  = 12;
  localparam int REG_W   = 32;
  localparam int NWIRED  = NCAUSE - 1;
  localparam int EXTRA_W = REG_W - NWIRED;

  localparam int C_WRPAR   = 0;
  localparam int C_RDPAR   = 1;
  localparam int C_SBE     = 2;
  localparam int C_SBE_THR = 3;
  localparam int C_DBE     = 4;
  localparam int C_CATTRIP = 5;
  localparam int C_TEMP    = 6;
  localparam int C_TRAIN   = 7;
  localparam int C_INIT    = 8;
  localparam int C_OD_SBE  = 9;
  localparam int C_OD_DBE  = 10;
  localparam int C_OTHER   = 11;

  localparam logic [NCAUSE-1:0] ERR_MASK =
    NCAUSE'((1 << C_WRPAR) | (1 << C_RDPAR) | (1 << C_SBE) | (1 << C_SBE_THR) |
            (1 << C_DBE) | (1 << C_OD_SBE) | (1 << C_OD_DBE));
endpackage

// File: rtl/mecg_delta.sv
module mecg_delta #(
  parameter int W       = 1,
  parameter bit IS_RISE = 1'b1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d_i,
  output logic         ev_o
);
  logic [W-1:0] prev_q;
  logic         vld_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q <= '0;
      vld_q  <= 1'b0;
    end else begin
      prev_q <= d_i;
      vld_q  <= 1'b1;
    end
  end

  generate
    if (IS_RISE) begin : g_rise
      assign ev_o = |(d_i & ~prev_q);
    end else begin : g_change
      assign ev_o = vld_q && (d_i != prev_q);
    end
  endgenerate
endmodule

// File: rtl/mecg_sbe_cnt.sv
module mecg_sbe_cnt #(
  parameter int CNT_W    = 8,
  parameter int THR_INIT = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             inc_i,
  input  logic             clr_i,
  input  logic             thr_we_i,
  input  logic [CNT_W-1:0] thr_i,
  output logic             over_o
);
  localparam logic [CNT_W-1:0] CMAX = {CNT_W{1'b1}};

  logic [CNT_W-1:0] cnt_q, cnt_d, base;
  logic [CNT_W-1:0] thr_q;
  logic             cnt_en;

  always_comb begin
    base   = clr_i ? '0 : cnt_q;
    cnt_d  = (inc_i && base != CMAX) ? base + 1'b1 : base;
    cnt_en = inc_i | clr_i;
    over_o = inc_i && (cnt_d > thr_q);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        thr_q <= CNT_W'(THR_INIT);
    else if (thr_we_i) thr_q <= thr_i;
  end

  // R4: a saturated count holds while no clear arrives
  a_r4_saturate: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_q == CMAX && !clr_i) |=> (cnt_q == CMAX));
  // R4: a clear without an event returns the count to zero
  a_r4_clear_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_i && !inc_i) |=> (cnt_q == '0));
endmodule

// File: rtl/mecg_chan.sv
module mecg_chan
  import mecg_pkg::*;
#(
  parameter int CNT_W    = 8,
  parameter int TEMP_W   = 8,
  parameter int THR_INIT = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wr_par_i,
  input  logic               rd_par_i,
  input  logic               sbe_i,
  input  logic               dbe_i,
  input  logic               od_sbe_i,
  input  logic               od_dbe_i,
  input  logic               cattrip_i,
  input  logic [TEMP_W-1:0]  temp_i,
  input  logic               train_i,
  input  logic               init_i,
  input  logic [EXTRA_W-1:0] extra_i,
  input  logic               clr_we_i,
  input  logic               thr_we_i,
  input  logic [REG_W-1:0]   wdata_i,
  output logic [NCAUSE-1:0]  cause_o,
  output logic               rollup_o
);
  logic [REG_W-1:0] st_q, st_d, set_v, clr_v;
  logic             st_en;
  logic             sbe_over, temp_ev, train_ev, init_ev;

  mecg_sbe_cnt #(.CNT_W(CNT_W), .THR_INIT(THR_INIT)) u_cnt (
    .clk      (clk),
    .rst_n    (rst_n),
    .inc_i    (sbe_i),
    .clr_i    (clr_v[C_SBE]),
    .thr_we_i (thr_we_i),
    .thr_i    (wdata_i[CNT_W-1:0]),
    .over_o   (sbe_over)
  );

  mecg_delta #(.W(TEMP_W), .IS_RISE(1'b0)) u_temp (
    .clk (clk), .rst_n (rst_n), .d_i (temp_i), .ev_o (temp_ev)
  );
  mecg_delta #(.W(1), .IS_RISE(1'b1)) u_train (
    .clk (clk), .rst_n (rst_n), .d_i (train_i), .ev_o (train_ev)
  );
  mecg_delta #(.W(1), .IS_RISE(1'b1)) u_init (
    .clk (clk), .rst_n (rst_n), .d_i (init_i), .ev_o (init_ev)
  );

  always_comb begin
    set_v                    = '0;
    set_v[C_WRPAR]           = wr_par_i;
    set_v[C_RDPAR]           = rd_par_i;
    set_v[C_SBE]             = sbe_i;
    set_v[C_SBE_THR]         = sbe_over;
    set_v[C_DBE]             = dbe_i;
    set_v[C_CATTRIP]         = cattrip_i;
    set_v[C_TEMP]            = temp_ev;
    set_v[C_TRAIN]           = train_ev;
    set_v[C_INIT]            = init_ev;
    set_v[C_OD_SBE]          = od_sbe_i;
    set_v[C_OD_DBE]          = od_dbe_i;
    set_v[REG_W-1:NWIRED]    = extra_i;
    clr_v                    = clr_we_i ? wdata_i : '0;
    clr_v[C_CATTRIP]         = 1'b0;
    st_d                     = set_v | (st_q & ~clr_v);
    st_en                    = (|set_v) | (|clr_v);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     st_q <= '0;
    else if (st_en) st_q <= st_d;
  end

  always_comb begin
    cause_o          = '0;
    cause_o[NWIRED-1:0] = st_q[NWIRED-1:0];
    cause_o[C_OTHER] = |st_q[REG_W-1:NWIRED];
    rollup_o         = |(cause_o & ERR_MASK);
  end

  // R7: the catastrophic-temperature bit never drops outside reset
  a_r7_cattrip_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    st_q[C_CATTRIP] |=> st_q[C_CATTRIP]);
  // R2: a clear with no competing event removes the bit
  a_r2_clear_takes: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_we_i && wdata_i[C_WRPAR] && !wr_par_i) |=> !st_q[C_WRPAR]);
  // R2: a same-cycle event beats the clear
  a_r2_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
    wr_par_i |=> st_q[C_WRPAR]);
  // R6: training cause only appears after the flag was seen high
  a_r6_train_rise: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(st_q[C_TRAIN]) |-> $past(train_i));
endmodule

// File: rtl/mem_err_cause_gen.sv
module mem_err_cause_gen
  import mecg_pkg::*;
#(
  parameter int NCH      = 4,
  parameter int CNT_W    = 8,
  parameter int TEMP_W   = 8,
  parameter int THR_INIT = 4,
  localparam int CH_W    = (NCH > 1) ? $clog2(NCH) : 1
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic [NCH-1:0]         wr_par_i,
  input  logic [NCH-1:0]         rd_par_i,
  input  logic [NCH-1:0]         sbe_i,
  input  logic [NCH-1:0]         dbe_i,
  input  logic [NCH-1:0]         od_sbe_i,
  input  logic [NCH-1:0]         od_dbe_i,
  input  logic [NCH-1:0]         cattrip_i,
  input  logic [NCH*TEMP_W-1:0]  temp_i,
  input  logic [NCH-1:0]         train_done_i,
  input  logic [NCH-1:0]         init_done_i,
  input  logic [NCH*EXTRA_W-1:0] extra_i,
  input  logic                   cfg_we_i,
  input  logic [CH_W-1:0]        cfg_ch_i,
  input  logic                   cfg_sel_i,
  input  logic [REG_W-1:0]       cfg_wdata_i,
  output logic [NCH*NCAUSE-1:0]  cause_o,
  output logic [NCH-1:0]         rollup_o
);
  logic [NCH-1:0] clr_we, thr_we;

  generate
    for (genvar g = 0; g < NCH; g++) begin : g_ch
      always_comb begin
        clr_we[g] = cfg_we_i && (cfg_ch_i == CH_W'(g)) && !cfg_sel_i;
        thr_we[g] = cfg_we_i && (cfg_ch_i == CH_W'(g)) &&  cfg_sel_i;
      end

      mecg_chan #(.CNT_W(CNT_W), .TEMP_W(TEMP_W), .THR_INIT(THR_INIT)) u_chan (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_par_i  (wr_par_i[g]),
        .rd_par_i  (rd_par_i[g]),
        .sbe_i     (sbe_i[g]),
        .dbe_i     (dbe_i[g]),
        .od_sbe_i  (od_sbe_i[g]),
        .od_dbe_i  (od_dbe_i[g]),
        .cattrip_i (cattrip_i[g]),
        .temp_i    (temp_i[g*TEMP_W +: TEMP_W]),
        .train_i   (train_done_i[g]),
        .init_i    (init_done_i[g]),
        .extra_i   (extra_i[g*EXTRA_W +: EXTRA_W]),
        .clr_we_i  (clr_we[g]),
        .thr_we_i  (thr_we[g]),
        .wdata_i   (cfg_wdata_i),
        .cause_o   (cause_o[g*NCAUSE +: NCAUSE]),
        .rollup_o  (rollup_o[g])
      );
    end
  endgenerate

  // R10: at most one channel decodes any configuration write
  a_r10_one_target: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(clr_we | thr_we));
endmodule

// File: tb/sim_mem_err_cause_gen.sv
module sim_mem_err_cause_gen;
  localparam int NCH = 4;
  localparam int TW  = 8;
  localparam int XW  = 21;

  // ops
  localparam int O_WR = 0, O_RD = 1, O_SBE = 2, O_DBE = 3, O_ODS = 4, O_ODD = 5,
                 O_CAT = 6, O_TEMP = 7, O_TRAIN = 8, O_INIT = 9, O_MISC = 10,
                 O_CLR = 11, O_THR = 12;

  // entry: {ch[1:0], op[3:0], arg[31:0], exp[11:0]}
  localparam int NT = 36;
  localparam logic [49:0] TBL [NT] = '{
    {2'd0, 4'd0,  32'h0,        12'h001},  // R1 write parity
    {2'd0, 4'd11, 32'h1,        12'h000},  // R2 clear
    {2'd0, 4'd1,  32'h0,        12'h002},  // R1 read parity
    {2'd0, 4'd3,  32'h0,        12'h012},  // R1 double-bit
    {2'd0, 4'd11, 32'hFFFFFFFF, 12'h000},  // R2 clear all
    {2'd0, 4'd2,  32'd1,        12'h004},  // R3 count 1
    {2'd0, 4'd2,  32'd3,        12'h004},  // R3 count 4 == thr
    {2'd0, 4'd2,  32'd1,        12'h00C},  // R3 count 5 > thr
    {2'd0, 4'd11, 32'h8,        12'h004},  // R3 clear cause 3 only
    {2'd0, 4'd2,  32'd1,        12'h00C},  // R3 re-fire, count kept
    {2'd0, 4'd11, 32'h4,        12'h008},  // R4 clear bit 2 resets count
    {2'd0, 4'd11, 32'h8,        12'h000},  // R2
    {2'd0, 4'd2,  32'd4,        12'h004},  // R4 count restarted at 0
    {2'd0, 4'd11, 32'h4,        12'h000},  // R4
    {2'd0, 4'd12, 32'd1,        12'h000},  // R3 threshold alone sets nothing
    {2'd0, 4'd2,  32'd2,        12'h00C},  // R3 new threshold
    {2'd0, 4'd11, 32'hFFF,      12'h000},  // R2
    {2'd0, 4'd6,  32'h0,        12'h020},  // R7 cattrip
    {2'd0, 4'd11, 32'hFFFFFFFF, 12'h020},  // R7 clear ignored
    {2'd0, 4'd7,  32'h35,       12'h060},  // R5 temp change
    {2'd0, 4'd11, 32'h40,       12'h020},  // R2
    {2'd0, 4'd7,  32'h35,       12'h020},  // R5 same value
    {2'd0, 4'd8,  32'd1,        12'h0A0},  // R6 training rise
    {2'd0, 4'd11, 32'h80,       12'h020},  // R6 held high no refire
    {2'd0, 4'd9,  32'd1,        12'h120},  // R6 init rise
    {2'd0, 4'd4,  32'h0,        12'h320},  // R1 on-die single
    {2'd0, 4'd5,  32'h0,        12'h720},  // R1 on-die double
    {2'd0, 4'd10, 32'd0,        12'hF20},  // R8 extra bit 0
    {2'd0, 4'd11, 32'h800,      12'h720},  // R8
    {2'd0, 4'd10, 32'd20,       12'hF20},  // R8 extra bit 20
    {2'd0, 4'd11, 32'h80000000, 12'h720},  // R8
    {2'd0, 4'd8,  32'd0,        12'h720},  // R6 falling no event
    {2'd0, 4'd8,  32'd1,        12'h7A0},  // R6 second rise
    {2'd2, 4'd0,  32'h0,        12'h001},  // R10 other channel
    {2'd2, 4'd7,  32'h07,       12'h041},  // R10 / R5
    {2'd0, 4'd7,  32'h36,       12'h7E0}   // R5
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [NCH-1:0] wr_par = '0, rd_par = '0, sbe = '0, dbe = '0, ods = '0, odd = '0;
  logic [NCH-1:0] cat = '0, train = '0, init = '0;
  logic [NCH*TW-1:0] temp = '0;
  logic [NCH*XW-1:0] extra = '0;
  logic        cfg_we = 1'b0;
  logic [1:0]  cfg_ch = '0;
  logic        cfg_sel = 1'b0;
  logic [31:0] cfg_wdata = '0;
  logic [NCH*12-1:0] cause;
  logic [NCH-1:0]    rollup;

  int n_chk = 0, n_bad = 0, cyc = 0;
  logic [11:0] model [NCH];

  always #2 clk = ~clk;  // 250 MHz

  mem_err_cause_gen #(.NCH(NCH)) u0 (
    .clk (clk), .rst_n (rst_n),
    .wr_par_i (wr_par), .rd_par_i (rd_par), .sbe_i (sbe), .dbe_i (dbe),
    .od_sbe_i (ods), .od_dbe_i (odd), .cattrip_i (cat), .temp_i (temp),
    .train_done_i (train), .init_done_i (init), .extra_i (extra),
    .cfg_we_i (cfg_we), .cfg_ch_i (cfg_ch), .cfg_sel_i (cfg_sel),
    .cfg_wdata_i (cfg_wdata), .cause_o (cause), .rollup_o (rollup)
  );

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc == 100000) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: run hung, actual cycles=%0d expected<100000", cyc);
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end

  task automatic check_all(string tag);
    for (int c = 0; c < NCH; c++) begin
      logic [11:0] got;
      logic        exp_r;
      got   = cause[c*12 +: 12];
      exp_r = |(model[c] & 12'h61F);  // R9 rollup of causes 0,1,2,3,4,9,10
      n_chk++;
      if (got !== model[c] || rollup[c] !== exp_r) begin
        n_bad++;
        $display("FAIL %s ch%0d: actual cause=%h rollup=%b expected cause=%h rollup=%b",
                 tag, c, got, rollup[c], model[c], exp_r);
      end
    end
  endtask

  task automatic run_op(int ch, int op, logic [31:0] arg);
    case (op)
      O_WR:  begin wr_par[ch] = 1'b1; @(negedge clk); wr_par[ch] = 1'b0; end
      O_RD:  begin rd_par[ch] = 1'b1; @(negedge clk); rd_par[ch] = 1'b0; end
      O_SBE: begin sbe[ch] = 1'b1; repeat (int'(arg)) @(negedge clk); sbe[ch] = 1'b0; end
      O_DBE: begin dbe[ch] = 1'b1; @(negedge clk); dbe[ch] = 1'b0; end
      O_ODS: begin ods[ch] = 1'b1; @(negedge clk); ods[ch] = 1'b0; end
      O_ODD: begin odd[ch] = 1'b1; @(negedge clk); odd[ch] = 1'b0; end
      O_CAT: begin cat[ch] = 1'b1; @(negedge clk); cat[ch] = 1'b0; end
      O_TEMP:  begin temp[ch*TW +: TW] = arg[TW-1:0]; @(negedge clk); end
      O_TRAIN: begin train[ch] = arg[0]; @(negedge clk); end
      O_INIT:  begin init[ch] = arg[0]; @(negedge clk); end
      O_MISC:  begin extra[ch*XW + int'(arg)] = 1'b1; @(negedge clk);
                     extra[ch*XW + int'(arg)] = 1'b0; end
      O_CLR, O_THR: begin
        cfg_we = 1'b1; cfg_ch = 2'(ch); cfg_sel = (op == O_THR);
        cfg_wdata = arg; @(negedge clk); cfg_we = 1'b0;
      end
      default: ;
    endcase
  endtask

  initial begin
    for (int c = 0; c < NCH; c++) model[c] = '0;
    repeat (3) @(negedge clk);
    check_all("R11 in reset");
    rst_n = 1'b1;
    @(negedge clk);
    check_all("R11 after reset");

    for (int i = 0; i < NT; i++) begin
      int ch, op;
      ch = int'(TBL[i][49:48]);
      op = int'(TBL[i][47:44]);
      run_op(ch, op, TBL[i][43:12]);
      model[ch] = TBL[i][11:0];
      check_all($sformatf("R1-table step %0d op %0d", i, op));
    end

    // R2: same-cycle set and clear on channel 1, set wins
    wr_par[1] = 1'b1; cfg_we = 1'b1; cfg_ch = 2'd1; cfg_sel = 1'b0; cfg_wdata = 32'h1;
    @(negedge clk);
    wr_par[1] = 1'b0; cfg_we = 1'b0;
    model[1] = 12'h001;
    check_all("R2 set beats clear");
    run_op(1, O_CLR, 32'hFFFFFFFF);
    model[1] = 12'h000;
    check_all("R2 clear ch1");

    // R4: saturation at 255 on channel 1 with threshold 254
    run_op(1, O_THR, 32'd254);
    run_op(1, O_SBE, 32'd300);
    model[1] = 12'h00C;
    check_all("R4 many events");
    run_op(1, O_CLR, 32'h8);
    model[1] = 12'h004;
    check_all("R4 clear cause 3");
    run_op(1, O_SBE, 32'd1);
    model[1] = 12'h00C;
    check_all("R4 saturated count still above threshold");

    // R7 / R11: reset clears the sticky catastrophic bit
    train = '0; init = '0;
    @(negedge clk);
    rst_n = 1'b0;
    #1;
    for (int c = 0; c < NCH; c++) model[c] = '0;
    check_all("R7 reset clears");
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    @(negedge clk);
    check_all("R5 no change flagged after reset");

    // R3: threshold back to reset value 4 after reset
    run_op(3, O_SBE, 32'd4);
    model[3] = 12'h004;
    check_all("R3 reset threshold equal");
    run_op(3, O_SBE, 32'd1);
    model[3] = 12'h00C;
    check_all("R3 reset threshold exceeded");

    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule